// File: doc/BRIEF.md
# Task-File Hidden Configuration Unlock Sequencer

This block sits on the register port of a disk-style device. It watches the host's register accesses for one ordered pattern. The pattern is two back-to-back 16-bit reads of register 1, followed by a byte write of 0x03 to register 2. When the pattern completes, the block switches the whole register window over to a small hidden bank of byte-wide configuration registers. While that bank is mapped, each offset addresses the configuration register with the same index. A byte write of 0x83 to offset 2 returns the window to the normal registers.

Before the unlock, every access, including the ones that make up the pattern, reaches a plain stub of the normal task-file registers. Inside the hidden bank, index 3 holds a channel control byte. Index 5 is a read-only strap that reports the bus clock speed.

Top module: `tfcfg_unlock`

## Requirements
- R1: After reset, `cfg_mapped`, `chan_on` and `rd_data` are 0. Every task-file register is 0. Every configuration register is 0, except index 3, which holds 0x11.
- R2: Two 16-bit reads of offset 1, followed by an 8-bit write of 0x03 to offset 2, set `cfg_mapped` in the cycle after the write. Further 16-bit reads of offset 1 before that write keep the sequence armed.
- R3: If any other access comes between the register-1 reads, or between those reads and the 0x03 write, the detector returns to its start. The unlock then does not happen.
- R4: An 8-bit read of offset 1 does not advance the sequence. At offset 2, a write of a value other than 0x03 does not complete it, and neither does a 16-bit write.
- R5: While unmapped, every read and write reaches the task-file registers, including the accesses that form the sequence. `chan_on` does not change while unmapped.
- R6: While mapped, a read or write at offset n reaches configuration register n. The configuration data is the low byte of `acc_wdata`, and reads return it zero-extended. The task-file registers are left untouched.
- R7: While mapped, an 8-bit write of 0x83 to offset 2 clears `cfg_mapped` in the next cycle and is not stored. A 16-bit write of 0x0083 to offset 2 is an ordinary configuration write.
- R8: Configuration register 3 stores any byte written to it. Writing 0x95 sets `chan_on`, writing 0x11 clears it, and any other value leaves it unchanged.
- R9: Configuration register 5 is read-only. It reads back {7'b0, `speed_strap`}, where 0 means a 33 MHz bus and 1 means a 25 MHz bus. Writes to it are ignored.
- R10: `rd_data` is loaded in the cycle after a read strobe and holds its value at all other times. A 16-bit task-file read returns the full register. An 8-bit read returns the zero-extended low byte. An 8-bit task-file write changes only the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Read strobe, one cycle per access |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| acc_ofs | input | OFS_W (3) | Register offset |
| acc_wdata | input | DATA_W (16) | Write data |
| speed_strap | input | 1 | Bus speed strap, 1 = 25 MHz |
| rd_data | output | DATA_W (16) | Registered read data |
| cfg_mapped | output | 1 | 1 while the hidden bank replaces the task file |
| chan_on | output | 1 | Channel enable state from control register 3 |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that each access lasts one strobe cycle, so a change of `cfg_mapped`, `chan_on` or `rd_data` can be traced to the single access in the cycle before it. The stimulus tasks meet both assumptions: each one drives exactly one access, or none, per cycle, and drops the strobes at the following falling edge. `speed_strap` changes only between accesses, so the strap property always sees a settled value.

// File: rtl/tfcfg_pkg.sv
package tfcfg_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_ONE  = 2'd1,
      SEQ_TWO  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/tfcfg_seq_detect.sv
module tfcfg_seq_detect
   import tfcfg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic acc_any,   // any read or write this cycle
   input  logic arm_rd,    // 16-bit read of the arming register
   input  logic open_wr,   // byte write of the open key
   input  logic close_wr,  // byte write of the close key
   output logic mapped
);
   seq_state_t state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         mapped <= 1'b0;
      end else if (mapped) begin
         state <= SEQ_IDLE;
         if (close_wr) mapped <= 1'b0;
      end else if (acc_any) begin
         case (state)
            SEQ_IDLE: state <= arm_rd ? SEQ_ONE : SEQ_IDLE;
            SEQ_ONE:  state <= arm_rd ? SEQ_TWO : SEQ_IDLE;
            SEQ_TWO: begin
               if (arm_rd) begin
                  state <= SEQ_TWO;
               end else begin
                  state <= SEQ_IDLE;
                  if (open_wr) mapped <= 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tfcfg_tf_stub.sv
module tfcfg_tf_stub
   import tfcfg_pkg::*;
#(
   parameter int unsigned OFS_W  = 3,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              wide,
   input  logic [OFS_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned NREG = 1 << OFS_W;

   logic [DATA_W-1:0] vec [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r <= '0;
         end else if (we && idx == OFS_W'(g)) begin
            if (wide) r <= wdata;
            else      r[BYTE_W-1:0] <= wdata[BYTE_W-1:0];
         end
      end
      assign vec[g] = r;
   end

   assign rdata = vec[idx];
endmodule

// File: rtl/tfcfg_cfg_bank.sv
module tfcfg_cfg_bank
   import tfcfg_pkg::*;
#(
   parameter int unsigned      OFS_W     = 3,
   parameter int unsigned      NUM_CFG   = 8,
   parameter int unsigned      CTRL_IDX  = 3,
   parameter int unsigned      STRAP_IDX = 5,
   parameter logic [BYTE_W-1:0] CTRL_ON  = 8'h95,
   parameter logic [BYTE_W-1:0] CTRL_OFF = 8'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [OFS_W-1:0]  idx,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              strap,
   output logic [BYTE_W-1:0] rdata,
   output logic              chan_on
);
   localparam int unsigned NREG = 1 << OFS_W;

   logic [BYTE_W-1:0] vec [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_cfg
      if (g == STRAP_IDX) begin : g_strap
         assign vec[g] = {{(BYTE_W-1){1'b0}}, strap};
      end else if (g < NUM_CFG) begin : g_store
         localparam logic [BYTE_W-1:0] RST_VAL = (g == CTRL_IDX) ? CTRL_OFF : '0;
         logic [BYTE_W-1:0] r;
         always_ff @(posedge clk) begin
            if (!rst_n)                        r <= RST_VAL;
            else if (we && idx == OFS_W'(g))   r <= wdata;
         end
         assign vec[g] = r;
      end else begin : g_absent
         assign vec[g] = '0;
      end
   end

   assign rdata = vec[idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_on <= 1'b0;
      end else if (we && idx == OFS_W'(CTRL_IDX)) begin
         if (wdata == CTRL_ON)       chan_on <= 1'b1;
         else if (wdata == CTRL_OFF) chan_on <= 1'b0;
      end
   end
endmodule

// File: rtl/tfcfg_unlock.sv
module tfcfg_unlock
   import tfcfg_pkg::*;
#(
   parameter int unsigned       OFS_W     = 3,
   parameter int unsigned       DATA_W    = 16,
   parameter int unsigned       NUM_CFG   = 8,
   parameter int unsigned       ARM_REG   = 1,
   parameter int unsigned       KEY_REG   = 2,
   parameter logic [BYTE_W-1:0] KEY_OPEN  = 8'h03,
   parameter logic [BYTE_W-1:0] KEY_CLOSE = 8'h83,
   parameter int unsigned       CTRL_IDX  = 3,
   parameter int unsigned       STRAP_IDX = 5,
   parameter logic [BYTE_W-1:0] CTRL_ON   = 8'h95,
   parameter logic [BYTE_W-1:0] CTRL_OFF  = 8'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_rd,
   input  logic              acc_wr,
   input  logic              acc_wide,
   input  logic [OFS_W-1:0]  acc_ofs,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              speed_strap,
   output logic [DATA_W-1:0] rd_data,
   output logic              cfg_mapped,
   output logic              chan_on
);
   localparam int unsigned NREG  = 1 << OFS_W;
   localparam int unsigned PAD_W = DATA_W - BYTE_W;

   if (DATA_W <= BYTE_W)         begin : g_bad_w   $error("DATA_W must exceed a byte"); end
   if (NUM_CFG > NREG)           begin : g_bad_n   $error("NUM_CFG exceeds offset space"); end
   if (ARM_REG >= NREG || KEY_REG >= NREG || ARM_REG == KEY_REG)
                                 begin : g_bad_key $error("bad arming/key offsets"); end
   if (CTRL_IDX >= NUM_CFG || STRAP_IDX >= NUM_CFG || CTRL_IDX == STRAP_IDX)
                                 begin : g_bad_idx $error("bad control/strap indices"); end
   if (CTRL_ON == CTRL_OFF)      begin : g_bad_ctl $error("control codes must differ"); end

   logic key_byte_wr, arm_rd, open_wr, close_wr;
   logic tf_we, cfg_we;
   logic [DATA_W-1:0] tf_rdata;
   logic [BYTE_W-1:0] cfg_rdata;

   assign key_byte_wr = acc_wr && !acc_wide && acc_ofs == OFS_W'(KEY_REG);
   assign arm_rd      = acc_rd && acc_wide && acc_ofs == OFS_W'(ARM_REG);
   assign open_wr     = key_byte_wr && acc_wdata[BYTE_W-1:0] == KEY_OPEN;
   assign close_wr    = key_byte_wr && acc_wdata[BYTE_W-1:0] == KEY_CLOSE;
   assign tf_we       = acc_wr && !cfg_mapped;
   assign cfg_we      = acc_wr && cfg_mapped && !close_wr;

   tfcfg_seq_detect u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_any  (acc_rd || acc_wr),
      .arm_rd   (arm_rd),
      .open_wr  (open_wr),
      .close_wr (close_wr),
      .mapped   (cfg_mapped)
   );

   tfcfg_tf_stub #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_tf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tf_we),
      .wide  (acc_wide),
      .idx   (acc_ofs),
      .wdata (acc_wdata),
      .rdata (tf_rdata)
   );

   tfcfg_cfg_bank #(
      .OFS_W(OFS_W), .NUM_CFG(NUM_CFG), .CTRL_IDX(CTRL_IDX),
      .STRAP_IDX(STRAP_IDX), .CTRL_ON(CTRL_ON), .CTRL_OFF(CTRL_OFF)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .idx     (acc_ofs),
      .wdata   (acc_wdata[BYTE_W-1:0]),
      .strap   (speed_strap),
      .rdata   (cfg_rdata),
      .chan_on (chan_on)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (acc_rd) begin
         if (cfg_mapped)    rd_data <= {{PAD_W{1'b0}}, cfg_rdata};
         else if (acc_wide) rd_data <= tf_rdata;
         else               rd_data <= {{PAD_W{1'b0}}, tf_rdata[BYTE_W-1:0]};
      end
   end
endmodule

// File: rtl/tfcfg_unlock_chk.sv
module tfcfg_unlock_chk
   import tfcfg_pkg::*;
#(
   parameter int unsigned       OFS_W     = 3,
   parameter int unsigned       DATA_W    = 16,
   parameter int unsigned       KEY_REG   = 2,
   parameter logic [BYTE_W-1:0] KEY_OPEN  = 8'h03,
   parameter logic [BYTE_W-1:0] KEY_CLOSE = 8'h83,
   parameter int unsigned       CTRL_IDX  = 3,
   parameter int unsigned       STRAP_IDX = 5,
   parameter logic [BYTE_W-1:0] CTRL_ON   = 8'h95,
   parameter logic [BYTE_W-1:0] CTRL_OFF  = 8'h11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_rd,
   input logic              acc_wr,
   input logic              acc_wide,
   input logic [OFS_W-1:0]  acc_ofs,
   input logic [DATA_W-1:0] acc_wdata,
   input logic              speed_strap,
   input logic [DATA_W-1:0] rd_data,
   input logic              cfg_mapped,
   input logic              chan_on
);
   assert_open_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_mapped) |-> $past(acc_wr && !acc_wide && acc_ofs == OFS_W'(KEY_REG)
                                  && acc_wdata[BYTE_W-1:0] == KEY_OPEN));

   assert_close_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_mapped) |-> $past(acc_wr && !acc_wide && acc_ofs == OFS_W'(KEY_REG)
                                  && acc_wdata[BYTE_W-1:0] == KEY_CLOSE));

   assert_chan_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_on) |-> $past(cfg_mapped && acc_wr && acc_ofs == OFS_W'(CTRL_IDX)
                               && acc_wdata[BYTE_W-1:0] == CTRL_ON));

   assert_chan_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_on) |-> $past(cfg_mapped && acc_wr && acc_ofs == OFS_W'(CTRL_IDX)
                               && acc_wdata[BYTE_W-1:0] == CTRL_OFF));

   assert_locked_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mapped |=> $stable(chan_on));

   assert_strap_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mapped && acc_rd && acc_ofs == OFS_W'(STRAP_IDX))
      |=> rd_data == {{(DATA_W-1){1'b0}}, $past(speed_strap)});

   assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rd |=> $stable(rd_data));
endmodule

bind tfcfg_unlock tfcfg_unlock_chk #(
   .OFS_W(OFS_W), .DATA_W(DATA_W), .KEY_REG(KEY_REG), .KEY_OPEN(KEY_OPEN),
   .KEY_CLOSE(KEY_CLOSE), .CTRL_IDX(CTRL_IDX), .STRAP_IDX(STRAP_IDX),
   .CTRL_ON(CTRL_ON), .CTRL_OFF(CTRL_OFF)
) chk_i (
   .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
   .acc_wide(acc_wide), .acc_ofs(acc_ofs), .acc_wdata(acc_wdata),
   .speed_strap(speed_strap), .rd_data(rd_data), .cfg_mapped(cfg_mapped),
   .chan_on(chan_on)
);

// File: tb/tfcfg_unlock_tb_top.sv
`timescale 1ns/1ps
module tfcfg_unlock_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_rd = 1'b0, acc_wr = 1'b0, acc_wide = 1'b0;
   logic [2:0]  acc_ofs = '0;
   logic [15:0] acc_wdata = '0;
   logic        speed_strap = 1'b0;
   logic [15:0] rd_data;
   logic        cfg_mapped, chan_on;

   int total = 0, bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tfcfg_unlock dut_i (
      .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
      .acc_wide(acc_wide), .acc_ofs(acc_ofs), .acc_wdata(acc_wdata),
      .speed_strap(speed_strap), .rd_data(rd_data),
      .cfg_mapped(cfg_mapped), .chan_on(chan_on)
   );

   // behavioural reference model
   logic [15:0] m_tf [8];
   logic [7:0]  m_cfg [8];
   int          m_armed;
   bit          m_map, m_chan;
   logic [15:0] m_rd;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_tf[i])  m_tf[i]  = 16'h0;
         foreach (m_cfg[i]) m_cfg[i] = 8'h0;
         m_cfg[3] = 8'h11;
         m_armed = 0; m_map = 0; m_chan = 0; m_rd = 16'h0;
      end else begin
         if (acc_rd) begin
            if (m_map)         m_rd = (acc_ofs == 3'd5) ? {15'h0, speed_strap} : {8'h0, m_cfg[acc_ofs]};
            else if (acc_wide) m_rd = m_tf[acc_ofs];
            else               m_rd = {8'h0, m_tf[acc_ofs][7:0]};
         end
         if (m_map) begin
            if (acc_wr) begin
               if (!acc_wide && acc_ofs == 3'd2 && acc_wdata[7:0] == 8'h83) begin
                  m_map = 0;
               end else if (acc_ofs != 3'd5) begin
                  m_cfg[acc_ofs] = acc_wdata[7:0];
                  if (acc_ofs == 3'd3 && acc_wdata[7:0] == 8'h95) m_chan = 1;
                  if (acc_ofs == 3'd3 && acc_wdata[7:0] == 8'h11) m_chan = 0;
               end
            end
         end else begin
            if (acc_wr) begin
               if (acc_wide) m_tf[acc_ofs] = acc_wdata;
               else          m_tf[acc_ofs][7:0] = acc_wdata[7:0];
            end
            if (acc_rd && acc_wide && acc_ofs == 3'd1)
               m_armed = (m_armed >= 1) ? 2 : 1;
            else if (acc_wr && !acc_wide && acc_ofs == 3'd2 && acc_wdata[7:0] == 8'h03 && m_armed == 2) begin
               m_map = 1; m_armed = 0;
            end else if (acc_rd || acc_wr)
               m_armed = 0;
         end
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R10 model rd_data", rd_data, m_rd);
         chk("R2 model cfg_mapped", {15'h0, cfg_mapped}, {15'h0, m_map});
         chk("R8 model chan_on", {15'h0, chan_on}, {15'h0, m_chan});
      end
   end

   task automatic acc(input logic r, input logic w, input logic wd, input int o, input logic [15:0] d);
      acc_rd = r; acc_wr = w; acc_wide = wd; acc_ofs = 3'(o); acc_wdata = d;
      @(negedge clk);
      acc_rd = 1'b0; acc_wr = 1'b0;
   endtask
   task automatic rd16(input int o);                  acc(1, 0, 1, o, 16'h0); endtask
   task automatic rd8(input int o);                   acc(1, 0, 0, o, 16'h0); endtask
   task automatic wr16(input int o, input logic [15:0] d); acc(0, 1, 1, o, d); endtask
   task automatic wr8(input int o, input logic [7:0] d);   acc(0, 1, 0, o, {8'hEE, d}); endtask
   task automatic unlock(); rd16(1); rd16(1); wr8(2, 8'h03); endtask

   task automatic summary();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset mapped", {15'h0, cfg_mapped}, 16'h0);
      chk("R1 reset chan_on", {15'h0, chan_on}, 16'h0);
      chk("R1 reset rd_data", rd_data, 16'h0);
      rd16(6);  chk("R1 task-file reset", rd_data, 16'h0);

      // locked pass-through and widths
      wr16(0, 16'hA5C3); wr8(4, 8'h34); wr16(7, 16'h1111); wr8(7, 8'h22);
      rd16(0);  chk("R5 wide tf read", rd_data, 16'hA5C3);
      rd8(0);   chk("R10 byte tf read zero-extends", rd_data, 16'h00C3);
      rd16(4);  chk("R10 byte tf write low only", rd_data, 16'h0034);
      rd16(7);  chk("R10 byte write keeps high byte", rd_data, 16'h1122);
      repeat (2) @(negedge clk);
      chk("R10 rd_data held", rd_data, 16'h1122);

      // sequences that must not unlock
      rd8(1); rd8(1); wr8(2, 8'h03);
      chk("R4 byte reads do not arm", {15'h0, cfg_mapped}, 16'h0);
      rd16(1); rd16(1); wr8(2, 8'h04);
      chk("R4 wrong key value", {15'h0, cfg_mapped}, 16'h0);
      rd16(1); rd16(1); wr16(2, 16'h0003);
      chk("R4 wide key write", {15'h0, cfg_mapped}, 16'h0);
      rd16(1); rd16(0); rd16(1); wr8(2, 8'h03);
      chk("R3 access between arming reads", {15'h0, cfg_mapped}, 16'h0);
      rd16(1); rd16(1); wr16(0, 16'hA5C3); wr8(2, 8'h03);
      chk("R3 access before key write", {15'h0, cfg_mapped}, 16'h0);
      rd16(1); rd16(1); rd8(1); wr8(2, 8'h03);
      chk("R3 byte read before key write", {15'h0, cfg_mapped}, 16'h0);

      // unlock with an extra arming read
      rd16(1); rd16(1); rd16(1); wr8(2, 8'h03);
      chk("R2 unlock", {15'h0, cfg_mapped}, 16'h0001);
      rd16(0);  chk("R1 cfg0 reset", rd_data, 16'h0000);
      rd8(3);   chk("R1 control reset value", rd_data, 16'h0011);
      wr8(0, 8'h5A); rd16(0); chk("R6 cfg write/read", rd_data, 16'h005A);
      wr16(4, 16'hBEEF); rd16(4); chk("R6 cfg low byte only", rd_data, 16'h00EF);

      // strap
      speed_strap = 1'b1;
      rd16(5);  chk("R9 strap 25 MHz", rd_data, 16'h0001);
      wr8(5, 8'hFE); rd16(5); chk("R9 strap write ignored", rd_data, 16'h0001);
      speed_strap = 1'b0;
      rd8(5);   chk("R9 strap 33 MHz", rd_data, 16'h0000);

      // control register
      wr8(3, 8'h95); chk("R8 enable code", {15'h0, chan_on}, 16'h0001);
      wr8(3, 8'h42); chk("R8 other code keeps state", {15'h0, chan_on}, 16'h0001);
      rd16(3);  chk("R8 control stores byte", rd_data, 16'h0042);
      wr8(3, 8'h11); chk("R8 disable code", {15'h0, chan_on}, 16'h0000);
      wr8(3, 8'h95);

      // wide 0x0083 is an ordinary write
      wr16(2, 16'h0083);
      chk("R7 wide 0x83 does not close", {15'h0, cfg_mapped}, 16'h0001);
      rd16(2);  chk("R7 wide 0x83 stored", rd_data, 16'h0083);
      wr8(2, 8'h00);

      // close
      wr8(2, 8'h83);
      chk("R7 close", {15'h0, cfg_mapped}, 16'h0000);
      rd16(2);  chk("R5 key write reached task file", rd_data, 16'h0003);
      rd16(0);  chk("R6 task file untouched by cfg writes", rd_data, 16'hA5C3);
      wr8(3, 8'h11);
      chk("R5 chan_on unchanged while locked", {15'h0, chan_on}, 16'h0001);
      rd16(3);  chk("R5 locked write hits task file", rd_data, 16'h0011);

      unlock();
      chk("R2 second unlock", {15'h0, cfg_mapped}, 16'h0001);
      rd16(2);  chk("R7 close key not stored", rd_data, 16'h0000);
      rd16(0);  chk("R6 cfg kept across relock", rd_data, 16'h005A);
      wr8(2, 8'h83);
      chk("R7 close again", {15'h0, cfg_mapped}, 16'h0000);

      repeat (2) @(negedge clk);
      summary();
   end
endmodule